// File: doc/BRIEF.md
# Serial RAM Identification Probe Sequencer

This block runs once after power-up, or whenever software pulses a start, to identify a serial pseudo-static RAM. It talks to the device through a byte-wide SPI shifter. The block sends one command per handshake and waits until the shifter reports that it is idle before it sends the next command.

The probe has two phases. In the first phase, the block selects the device, sends a reset-enable command on four lanes, drops the reply and deselects the device. In the second phase, it selects the device again and runs seven single-lane byte slots. The first slot carries the read-ID opcode and the remaining six carry filler bytes. Two of the reply bytes are kept: the known-good-die marker and the extended ID. From these two bytes the block decides whether a device is present and decodes its capacity in MiB. It then compares that capacity with an expected value and returns one of three verdicts: pass, size mismatch or absent.

The verdict and the decoded size stay on the outputs until the next accepted start. A one-cycle done pulse marks the moment they become valid.

Top module: `ramid_probe`

States: `ST_IDLE`, `ST_RST_WAIT`, `ST_RST_SEND`, `ST_RST_DRAIN`, `ST_DESEL`, `ST_ID_SEND`, `ST_ID_DRAIN`, `ST_DECIDE`.

Transitions:
- `ST_IDLE` to `ST_RST_WAIT` on start.
- `ST_RST_WAIT` to `ST_RST_SEND` when the shifter is idle.
- `ST_RST_SEND` to `ST_RST_DRAIN` always.
- `ST_RST_DRAIN` to `ST_DESEL` when the shifter is idle.
- `ST_DESEL` to `ST_ID_SEND` always.
- `ST_ID_SEND` to `ST_ID_DRAIN` always.
- `ST_ID_DRAIN` to `ST_ID_SEND` when the shifter is idle and this is not the last slot.
- `ST_ID_DRAIN` to `ST_DECIDE` when the shifter is idle and this is the last slot.
- `ST_DECIDE` to `ST_IDLE` always.

## Requirements
- R1: After reset, chip select, transmit-valid, busy, done and result-valid are all 0.
- R2: After start, the block waits until the shifter is idle. It then asserts chip select and sends byte 0xF5 with the quad-lane output at 1. The reply to this byte does not affect the result.
- R3: Once the reset-enable byte has drained, chip select goes low for at least one cycle before the device is selected again.
- R4: The identification phase sends exactly seven bytes under one continuous chip select, with the quad-lane output at 0. Slot 0 sends 0x9F and slots 1 to 6 send 0xFF.
- R5: Each transmit-valid lasts exactly one cycle. A byte is sent only after a cycle in which the shifter showed transmit-empty at 1 and busy at 0. The shifter must raise busy before the clock edge that follows an accepted byte.
- R6: The reply in slot 5 is the known-good-die byte and the reply in slot 6 is the extended ID. If the known-good-die byte is not 0x5D, the status is absent (code 2) and the size is 0.
- R7: When the device is present, the size is taken from extended-ID bits [7:5]. Value 0 gives 2 MiB, value 1 gives 4 MiB, value 2 gives 8 MiB and any other value gives 1 MiB. An extended ID of exactly 0x26 gives 8 MiB.
- R8: A present device whose decoded size equals the expected size reports pass (code 0). Any other size reports mismatch (code 1).
- R9: Done is high for exactly one cycle, together with result-valid. Status and size then hold until the next accepted start, and that start clears result-valid in the following cycle.
- R10: A start received while a probe is running is ignored. No extra bytes are sent and no extra done pulse appears.
- R11: Chip select is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for the probe |
| expect_mib_i | input | 4 | Expected capacity in MiB |
| sh_tx_empty_i | input | 1 | Shifter transmit holding register is empty |
| sh_busy_i | input | 1 | Shifter is transferring a byte |
| sh_rx_byte_i | input | 8 | Byte received by the shifter in the last slot |
| sh_cs_o | output | 1 | Chip select, active high |
| sh_quad_o | output | 1 | 1 = four-lane transfer, 0 = single lane |
| sh_tx_valid_o | output | 1 | One-cycle strobe handing a byte to the shifter |
| sh_tx_byte_o | output | 8 | Byte handed to the shifter |
| busy_o | output | 1 | A probe is in progress |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| result_valid_o | output | 1 | Status and size are valid |
| status_o | output | 2 | 0 pass, 1 mismatch, 2 absent |
| size_mib_o | output | 4 | Decoded capacity in MiB |

## Verification
A wrong state or a wrong slot counter shows up first on the shifter side of the block, and it shows up within one byte slot. Typical symptoms are a wrong opcode or lane width, a missing chip-select gap, or more or fewer than seven identification bytes. These faults appear long before any verdict.

A reply captured from the wrong slot, or a decode error, only becomes visible at done. At that point the status and size disagree with the values expected for the reply bytes that were supplied. The replies are therefore chosen so that each decode branch can be told apart, including the 0x26 alias and the case where the marker is absent but the expected size is 0.

// File: rtl/ramid_pkg.sv
package ramid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_WAIT,
        ST_RST_SEND,
        ST_RST_DRAIN,
        ST_DESEL,
        ST_ID_SEND,
        ST_ID_DRAIN,
        ST_DECIDE
    } seq_state_e;

    typedef enum logic [1:0] {
        PR_PASS     = 2'd0,
        PR_MISMATCH = 2'd1,
        PR_ABSENT   = 2'd2
    } probe_status_e;

endpackage

// File: rtl/ramid_seq.sv
module ramid_seq
    import ramid_pkg::*;
#(
    parameter logic [7:0] CMD_RESET  = 8'hF5,
    parameter logic [7:0] CMD_READID = 8'h9F,
    parameter logic [7:0] FILLER     = 8'hFF,
    parameter int         N_SLOTS    = 7,
    parameter int         KGD_SLOT   = 5,
    parameter int         EID_SLOT   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sh_empty_i,
    input  logic       sh_busy_i,
    input  logic [7:0] sh_rx_i,
    output logic       sh_cs_o,
    output logic       sh_quad_o,
    output logic       sh_tx_valid_o,
    output logic [7:0] sh_tx_byte_o,
    output logic       run_o,
    output logic       decide_o,
    output logic [7:0] kgd_o,
    output logic [7:0] eid_o
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);
    localparam logic [SLOT_W-1:0] SLOT_KGD  = SLOT_W'(KGD_SLOT);
    localparam logic [SLOT_W-1:0] SLOT_EID  = SLOT_W'(EID_SLOT);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        kgd_q, eid_q;
    logic              idle_ok;

    assign idle_ok = sh_empty_i && !sh_busy_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_RST_WAIT;
            ST_RST_WAIT:  if (idle_ok) state_d = ST_RST_SEND;
            ST_RST_SEND:  state_d = ST_RST_DRAIN;
            ST_RST_DRAIN: if (idle_ok) state_d = ST_DESEL;
            ST_DESEL:     state_d = ST_ID_SEND;
            ST_ID_SEND:   state_d = ST_ID_DRAIN;
            ST_ID_DRAIN:  if (idle_ok) state_d = (slot_q == SLOT_LAST) ? ST_DECIDE : ST_ID_SEND;
            ST_DECIDE:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sh_cs_o       = 1'b0;
        sh_quad_o     = 1'b0;
        sh_tx_valid_o = 1'b0;
        sh_tx_byte_o  = FILLER;
        decide_o      = 1'b0;
        run_o         = (state_q != ST_IDLE);
        unique case (state_q)
            ST_RST_SEND: begin
                sh_cs_o = 1'b1; sh_quad_o = 1'b1; sh_tx_valid_o = 1'b1;
                sh_tx_byte_o = CMD_RESET;
            end
            ST_RST_DRAIN: begin
                sh_cs_o = 1'b1; sh_quad_o = 1'b1;
            end
            ST_ID_SEND: begin
                sh_cs_o = 1'b1; sh_tx_valid_o = 1'b1;
                sh_tx_byte_o = (slot_q == '0) ? CMD_READID : FILLER;
            end
            ST_ID_DRAIN: sh_cs_o = 1'b1;
            ST_DECIDE:   decide_o = 1'b1;
            default: ;
        endcase
    end

    // Slot counter and reply capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            kgd_q  <= '0;
            eid_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                kgd_q <= '0;
                eid_q <= '0;
            end
            if (state_q == ST_DESEL) begin
                slot_q <= '0;
            end else if (state_q == ST_ID_DRAIN && idle_ok) begin
                if (slot_q == SLOT_KGD) kgd_q <= sh_rx_i;
                if (slot_q == SLOT_EID) eid_q <= sh_rx_i;
                if (slot_q != SLOT_LAST) slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign kgd_o = kgd_q;
    assign eid_o = eid_q;

    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tx_valid_o |=> !sh_tx_valid_o); // R5
    AST_TX_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tx_valid_o |-> $past(sh_empty_i && !sh_busy_i)); // R5
    AST_TX_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tx_valid_o |-> sh_cs_o); // R4
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_quad_o) && run_o) |-> !sh_cs_o); // R3
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_LAST); // R4
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> !sh_cs_o); // R11

endmodule

// File: rtl/ramid_decode.sv
module ramid_decode
    import ramid_pkg::*;
#(
    parameter logic [7:0] KGD_OK    = 8'h5D,
    parameter logic [7:0] EID_ALIAS = 8'h26,
    parameter int         FIELD_LSB = 5,
    parameter int         MIB_W     = 4
) (
    input  logic [7:0]       kgd_i,
    input  logic [7:0]       eid_i,
    input  logic [MIB_W-1:0] expect_i,
    output logic [MIB_W-1:0] size_o,
    output probe_status_e    status_o
);
    localparam int FIELD_W = 8 - FIELD_LSB;

    logic               present;
    logic [FIELD_W-1:0] field;
    logic [MIB_W-1:0]   coded;

    assign present = (kgd_i == KGD_OK);
    assign field   = eid_i[7:FIELD_LSB];

    always_comb begin
        unique case (field)
            FIELD_W'(0): coded = MIB_W'(2);
            FIELD_W'(1): coded = MIB_W'(4);
            FIELD_W'(2): coded = MIB_W'(8);
            default:     coded = MIB_W'(1);
        endcase
        if (eid_i == EID_ALIAS) coded = MIB_W'(8);
    end

    always_comb begin
        size_o = present ? coded : '0;
        if (!present)              status_o = PR_ABSENT;
        else if (coded == expect_i) status_o = PR_PASS;
        else                        status_o = PR_MISMATCH;
    end

endmodule

// File: rtl/ramid_result.sv
module ramid_result
    import ramid_pkg::*;
#(
    parameter int MIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             decide_i,
    input  logic [MIB_W-1:0] size_i,
    input  probe_status_e    status_i,
    output logic             done_o,
    output logic             valid_o,
    output logic [MIB_W-1:0] size_o,
    output logic [1:0]       status_o
);
    logic [MIB_W-1:0] size_q;
    logic [1:0]       status_q;
    logic             done_q, valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= '0;
            status_q <= PR_PASS;
            done_q   <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            done_q <= decide_i;
            if (decide_i) begin
                size_q   <= size_i;
                status_q <= status_i;
                valid_q  <= 1'b1;
            end else if (start_i && !run_i) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign done_o   = done_q;
    assign valid_o  = valid_q;
    assign size_o   = size_q;
    assign status_o = status_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> ($stable(status_o) && $stable(size_o))); // R9
    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && status_o == PR_ABSENT) |-> size_o == '0); // R6

endmodule

// File: rtl/ramid_probe.sv
module ramid_probe
    import ramid_pkg::*;
#(
    parameter int MIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [MIB_W-1:0] expect_mib_i,
    input  logic             sh_tx_empty_i,
    input  logic             sh_busy_i,
    input  logic [7:0]       sh_rx_byte_i,
    output logic             sh_cs_o,
    output logic             sh_quad_o,
    output logic             sh_tx_valid_o,
    output logic [7:0]       sh_tx_byte_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             result_valid_o,
    output logic [1:0]       status_o,
    output logic [MIB_W-1:0] size_mib_o
);
    logic             run, decide;
    logic [7:0]       kgd, eid;
    logic [MIB_W-1:0] dec_size;
    probe_status_e    dec_status;

    ramid_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .sh_empty_i    (sh_tx_empty_i),
        .sh_busy_i     (sh_busy_i),
        .sh_rx_i       (sh_rx_byte_i),
        .sh_cs_o       (sh_cs_o),
        .sh_quad_o     (sh_quad_o),
        .sh_tx_valid_o (sh_tx_valid_o),
        .sh_tx_byte_o  (sh_tx_byte_o),
        .run_o         (run),
        .decide_o      (decide),
        .kgd_o         (kgd),
        .eid_o         (eid)
    );

    ramid_decode #(.MIB_W(MIB_W)) u_decode (
        .kgd_i    (kgd),
        .eid_i    (eid),
        .expect_i (expect_mib_i),
        .size_o   (dec_size),
        .status_o (dec_status)
    );

    ramid_result #(.MIB_W(MIB_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .run_i    (run),
        .decide_i (decide),
        .size_i   (dec_size),
        .status_i (dec_status),
        .done_o   (done_o),
        .valid_o  (result_valid_o),
        .size_o   (size_mib_o),
        .status_o (status_o)
    );

    assign busy_o = run;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> !done_o || !$past(sh_tx_valid_o)); // R10

endmodule

// File: tb/ramid_probe_tb_top.sv
`timescale 1ns/1ps
module ramid_probe_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] expect_mib = '0;
    logic       sh_empty = 1'b1;
    logic       sh_busy = 1'b0;
    logic [7:0] sh_rx = '0;
    logic       sh_cs, sh_quad, sh_tx_valid, busy, done, rvalid;
    logic [7:0] sh_tx_byte;
    logic [1:0] status;
    logic [3:0] size_mib;

    always #4 clk = ~clk;

    ramid_probe dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .expect_mib_i(expect_mib),
        .sh_tx_empty_i(sh_empty), .sh_busy_i(sh_busy), .sh_rx_byte_i(sh_rx),
        .sh_cs_o(sh_cs), .sh_quad_o(sh_quad), .sh_tx_valid_o(sh_tx_valid),
        .sh_tx_byte_o(sh_tx_byte), .busy_o(busy), .done_o(done),
        .result_valid_o(rvalid), .status_o(status), .size_mib_o(size_mib)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Shifter model, acting away from the active edge
    logic [7:0] dev_kgd = 8'h5D, dev_eid = 8'h40;
    logic [7:0] log_byte [16];
    logic       log_quad [16];
    int  tx_cnt = 0, sess = 0, lat = 0, done_cnt = 0, viol = 0;
    bit  gap_seen = 0;
    logic [7:0] pend = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (sh_tx_valid) begin
                if (sh_busy || !sh_empty) viol++;
                if (tx_cnt < 16) begin
                    log_byte[tx_cnt] = sh_tx_byte;
                    log_quad[tx_cnt] = sh_quad;
                end
                tx_cnt++;
                if (sh_quad)        pend = dev_kgd;
                else if (sess == 5) pend = dev_kgd;
                else if (sess == 6) pend = dev_eid;
                else                pend = 8'hA5;
                sess++;
                sh_busy = 1'b1; sh_empty = 1'b0; lat = 3;
            end else if (sh_busy) begin
                lat--;
                if (lat == 0) begin
                    sh_busy = 1'b0; sh_empty = 1'b1; sh_rx = pend;
                end
            end
            if (!sh_cs) begin
                sess = 0;
                if (tx_cnt == 1) gap_seen = 1;
            end
        end
    end

    task automatic run_probe(input logic [7:0] k, input logic [7:0] e,
                             input logic [3:0] ex, input logic [1:0] est,
                             input logic [3:0] esz, input bit extra_start);
        int n;
        dev_kgd = k; dev_eid = e; expect_mib = ex;
        tx_cnt = 0; gap_seen = 0; done_cnt = 0; viol = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(rvalid == 1'b0, "R9", "valid cleared by start", rvalid, 0);
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R9", "done seen", done, 1);
        check(status == est, "R8", "status", status, est);
        check(size_mib == esz, "R7", "size", size_mib, esz);
        check(rvalid == 1'b1, "R9", "valid with done", rvalid, 1);
        check(tx_cnt == 8, "R4", "byte count", tx_cnt, 8);
        check(log_byte[0] == 8'hF5 && log_quad[0], "R2", "reset-enable byte", log_byte[0], 8'hF5);
        check(gap_seen, "R3", "cs gap", gap_seen, 1);
        for (int i = 1; i < 8; i++)
            check(log_byte[i] == ((i == 1) ? 8'h9F : 8'hFF) && !log_quad[i], "R4",
                  "id slot byte", log_byte[i], (i == 1) ? 8'h9F : 8'hFF);
        check(viol == 0, "R5", "send while shifter busy", viol, 0);
        repeat (5) @(negedge clk);
        check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
        check(status == est && size_mib == esz && rvalid, "R9", "result held", status, est);
        check(!sh_cs && !busy, "R11", "idle cs", sh_cs, 0);
    endtask

    // {kgd, eid, expect, 2'b0, status, 4'b0, size}
    localparam int NV = 11;
    localparam logic [NV-1:0][31:0] VECS = {
        {8'h5D, 8'h40, 4'd8, 2'b0, 2'd0, 4'b0, 4'd8},
        {8'h5D, 8'h00, 4'd2, 2'b0, 2'd0, 4'b0, 4'd2},
        {8'h5D, 8'h20, 4'd4, 2'b0, 2'd0, 4'b0, 4'd4},
        {8'h5D, 8'h26, 4'd8, 2'b0, 2'd0, 4'b0, 4'd8},
        {8'h5D, 8'h26, 4'd4, 2'b0, 2'd1, 4'b0, 4'd8},
        {8'h5D, 8'h60, 4'd1, 2'b0, 2'd0, 4'b0, 4'd1},
        {8'h5D, 8'hE0, 4'd8, 2'b0, 2'd1, 4'b0, 4'd1},
        {8'h00, 8'h40, 4'd8, 2'b0, 2'd2, 4'b0, 4'd0},
        {8'h5C, 8'h00, 4'd0, 2'b0, 2'd2, 4'b0, 4'd0},
        {8'h5D, 8'h5F, 4'd8, 2'b0, 2'd0, 4'b0, 4'd8},
        {8'h5D, 8'h3F, 4'd2, 2'b0, 2'd1, 4'b0, 4'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!sh_cs && !sh_tx_valid && !busy && !done && !rvalid, "R1", "reset outputs",
              {sh_cs, sh_tx_valid, busy, done, rvalid}, 0);
        for (int v = 0; v < NV; v++)
            run_probe(VECS[v][31:24], VECS[v][23:16], VECS[v][15:12],
                      VECS[v][9:8], VECS[v][3:0], 1'b0);
        // R10: start during a running probe is ignored
        run_probe(8'h5D, 8'h20, 4'd4, 2'd0, 4'd4, 1'b1);
        // R6: marker absent overrides an otherwise matching size
        run_probe(8'hD5, 8'h20, 4'd4, 2'd2, 4'd0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule